// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal single-beat request bus and an external asynchronous static RAM of 128K bytes (17 address bits, one byte per location). It turns each accepted read or write into a sequence of registered pin strobes: a low-active chip enable and a high-active chip enable driven together, a write strobe, an output-enable strobe, and the output enable of the controller's own data pads. Each part of the sequence lasts a whole number of clock cycles. These counts are derived at elaboration from the clock period and the selected speed grade (fast or slow). Every timing figure becomes a cycle count by rounding up, with a floor of one cycle.

A requester raises `req_valid` with `req_write`, `req_addr` and `req_wdata`. It holds them until `req_ready` pulses, and may drop or change them in that same cycle. The controller samples the request only while idle. Each access runs through setup, strobe and recovery phases before the controller returns to idle. Read data appears on `rsp_rdata` in the same cycle as the `req_ready` pulse and stays there until the next read completes.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until a request is taken, the outputs rest as follows: `sram_ce1_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0 and `req_ready`=0.
- R2: A write selects the RAM (`sram_ce1_n`=0 together with `sram_ce2`=1) and pulses `sram_we_n` low while `sram_oe_n` stays high. When the pulse ends, the byte on `sram_dq_out` is stored at `sram_addr`, and a later read of that address returns it.
- R3: A read selects the RAM with `sram_oe_n`=0 and `sram_we_n`=1. `sram_dq_in` is captured only once the select and output-enable time covers the larger of the address access time and the output-enable access time (55/25 ns fast, 70/35 ns slow). The captured byte is returned on `rsp_rdata`.
- R4: The write pulse lasts at least as long as each of three figures: the pulse width (40/50 ns), the select-to-write-end time (40/60 ns), and the bus float time plus the data setup time. The RAM stays selected for the whole pulse. Two successive selections start at least one write cycle time (55/70 ns) apart.
- R5: Write data is driven only after the RAM's output float time (20/25 ns) following the fall of `sram_we_n`. It then stays stable for at least the data setup time (25/30 ns) before `sram_we_n` rises. `sram_addr` does not change while the RAM is selected.
- R6: `req_ready` is high for exactly one cycle per request: on the cycle the read byte is registered, or on the cycle after the write pulse ends.
- R7: `sram_dq_oe` is never high while the RAM may drive the bus (selected, `sram_oe_n`=0, `sram_we_n`=1). After `sram_oe_n` rises at least the bus release time (20/25 ns) passes before `sram_dq_oe` rises.
- R8: A request is taken only while idle, and its write flag, address and data are sampled then. Changes on the request inputs during an access do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| sram_addr | output | 17 | RAM address pins |
| sram_dq_out | output | 8 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Enable of the controller's data pads |
| sram_dq_in | input | 8 | Data received from the RAM |
| sram_ce1_n | output | 1 | Chip enable, active low |
| sram_ce2 | output | 1 | Chip enable, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume that `rst_n` is held low across at least one clock edge. They also assume that the requester keeps `req_valid` and its fields steady until `req_ready` and never expects a request to be taken during an access. The bench keeps to this. Its request task changes the request inputs only on falling clock edges and only after `req_ready`. The one deliberate exception is the case where the fields change during an access to show that they are ignored. A bench model of the RAM returns an inverted byte until the access time has passed. It commits a write when the write pulse ends, and it measures every strobe width and gap in cycles against figures the bench computes itself.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;

  // Timing figures in ns: {fast grade, slow grade}
  localparam int unsigned T_ACCESS_F  = 55;
  localparam int unsigned T_ACCESS_S  = 70;
  localparam int unsigned T_OE_ACC_F  = 25;
  localparam int unsigned T_OE_ACC_S  = 35;
  localparam int unsigned T_WCYC_F    = 55;
  localparam int unsigned T_WCYC_S    = 70;
  localparam int unsigned T_WPULSE_F  = 40;
  localparam int unsigned T_WPULSE_S  = 50;
  localparam int unsigned T_SEL_END_F = 40;
  localparam int unsigned T_SEL_END_S = 60;
  localparam int unsigned T_DSETUP_F  = 25;
  localparam int unsigned T_DSETUP_S  = 30;
  localparam int unsigned T_FLOAT_F   = 20;
  localparam int unsigned T_FLOAT_S   = 25;

  function automatic int unsigned grade_ns(bit slow, int unsigned fast_ns,
                                           int unsigned slow_ns);
    return slow ? slow_ns : fast_ns;
  endfunction

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned RD_LEN = 6,
  parameter int unsigned WE_LEN = 5,
  parameter int unsigned RD_REC = 2,
  parameter int unsigned WR_REC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_wr,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic             strobe_done
);

  logic [CNT_W-1:0] cnt_q;

  // next-state process
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    strobe_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          cnt_d   = '0;
        end
      end
      ST_SETUP: begin
        state_d = ST_STROBE;
        cnt_d   = op_wr ? CNT_W'(WE_LEN - 1) : CNT_W'(RD_LEN - 1);
      end
      ST_STROBE: begin
        if (cnt_q == '0) begin
          state_d     = ST_RECOVER;
          cnt_d       = op_wr ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
          strobe_done = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          strobe_done,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  output logic          op_wr_q,
  output logic          op_wr_d,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          ready_q
);

  logic capture_en;

  always_comb begin
    op_wr_d    = load ? req_write : op_wr_q;
    capture_en = strobe_done && !op_wr_q;
  end

  // request fields: clock enable = load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      op_wr_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // read byte: clock enable = capture_en
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_en) begin
      rdata_q <= dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= strobe_done;
    end
  end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned WE_LEN  = 5,
  parameter int unsigned FLT_LEN = 2,
  parameter bit          HOLD_DQ = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_e       state_q,
  input  seq_state_e       state_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             op_wr_d,
  output logic             ce1_n_q,
  output logic             ce2_q,
  output logic             we_n_q,
  output logic             oe_n_q,
  output logic             dq_oe_q
);

  // strobe counter runs WE_LEN-1 .. 0; drive once FLT_LEN cycles elapsed
  localparam int unsigned DRV_LIM = WE_LEN - FLT_LEN;

  logic sel_d, we_d, oe_d, drv_strobe, drv_hold, dq_oe_d;

  always_comb begin
    sel_d      = (state_d == ST_SETUP) || (state_d == ST_STROBE);
    we_d       = op_wr_d && (state_d == ST_STROBE);
    oe_d       = !op_wr_d && sel_d;
    drv_strobe = op_wr_d && (state_d == ST_STROBE) && (cnt_d < CNT_W'(DRV_LIM));
  end

  generate
    if (HOLD_DQ) begin : g_hold
      always_comb drv_hold = op_wr_d && (state_q == ST_STROBE) &&
                             (state_d == ST_RECOVER);
    end else begin : g_nohold
      always_comb drv_hold = 1'b0;
    end
  endgenerate

  always_comb dq_oe_d = drv_strobe || drv_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce1_n_q <= 1'b1;
      ce2_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      ce1_n_q <= !sel_d;
      ce2_q   <= sel_d;
      we_n_q  <= !we_d;
      oe_n_q  <= !oe_d;
      dq_oe_q <= dq_oe_d;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter bit          SLOW_GRADE    = 1'b0,
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n
);

  localparam int unsigned C_ACC   = ns_to_cyc(grade_ns(SLOW_GRADE, T_ACCESS_F,  T_ACCESS_S),  CLK_PERIOD_NS);
  localparam int unsigned C_OEACC = ns_to_cyc(grade_ns(SLOW_GRADE, T_OE_ACC_F,  T_OE_ACC_S),  CLK_PERIOD_NS);
  localparam int unsigned C_WCYC  = ns_to_cyc(grade_ns(SLOW_GRADE, T_WCYC_F,    T_WCYC_S),    CLK_PERIOD_NS);
  localparam int unsigned C_WPUL  = ns_to_cyc(grade_ns(SLOW_GRADE, T_WPULSE_F,  T_WPULSE_S),  CLK_PERIOD_NS);
  localparam int unsigned C_SELE  = ns_to_cyc(grade_ns(SLOW_GRADE, T_SEL_END_F, T_SEL_END_S), CLK_PERIOD_NS);
  localparam int unsigned C_DSU   = ns_to_cyc(grade_ns(SLOW_GRADE, T_DSETUP_F,  T_DSETUP_S),  CLK_PERIOD_NS);
  localparam int unsigned C_FLT   = ns_to_cyc(grade_ns(SLOW_GRADE, T_FLOAT_F,   T_FLOAT_S),   CLK_PERIOD_NS);

  localparam int unsigned RD_LEN  = max_u(C_ACC, C_OEACC);
  localparam int unsigned WE_LEN  = max_u(max_u(C_WPUL, C_SELE), C_FLT + C_DSU);
  localparam int unsigned RD_REC  = max_u(1, C_FLT);
  // one setup cycle precedes the pulse
  localparam int unsigned WR_REC  = (C_WCYC > WE_LEN + 2) ? (C_WCYC - WE_LEN - 1) : 1;
  localparam int unsigned MAX_LEN = max_u(max_u(RD_LEN, WE_LEN), max_u(RD_REC, WR_REC));
  localparam int unsigned CNT_W   = max_u(1, $clog2(MAX_LEN + 1));

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             strobe_done, start, op_wr_q, op_wr_d;

  always_comb start = (state_q == ST_IDLE) && req_valid;

  sram_cycle_seq #(
    .CNT_W (CNT_W),
    .RD_LEN(RD_LEN),
    .WE_LEN(WE_LEN),
    .RD_REC(RD_REC),
    .WR_REC(WR_REC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_wr      (op_wr_q),
    .state_q    (state_q),
    .state_d    (state_d),
    .cnt_d      (cnt_d),
    .strobe_done(strobe_done)
  );

  sram_req_latch #(
    .AW(AW),
    .DW(DW)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .strobe_done(strobe_done),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .dq_in      (sram_dq_in),
    .op_wr_q    (op_wr_q),
    .op_wr_d    (op_wr_d),
    .addr_q     (sram_addr),
    .wdata_q    (sram_dq_out),
    .rdata_q    (rsp_rdata),
    .ready_q    (req_ready)
  );

  sram_pin_drive #(
    .CNT_W  (CNT_W),
    .WE_LEN (WE_LEN),
    .FLT_LEN(C_FLT),
    .HOLD_DQ(1'b1)
  ) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .state_q(state_q),
    .state_d(state_d),
    .cnt_d  (cnt_d),
    .op_wr_d(op_wr_d),
    .ce1_n_q(sram_ce1_n),
    .ce2_q  (sram_ce2),
    .we_n_q (sram_we_n),
    .oe_n_q (sram_oe_n),
    .dq_oe_q(sram_dq_oe)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [AW-1:0] sram_addr,
  input logic [DW-1:0] sram_dq_out,
  input logic          sram_dq_oe,
  input logic          sram_ce1_n,
  input logic          sram_ce2,
  input logic          sram_we_n,
  input logic          sram_oe_n
);

  logic sel, ram_drives;
  always_comb begin
    sel        = !sram_ce1_n && sram_ce2;
    ram_drives = sel && !sram_oe_n && sram_we_n;
  end

  a_r2_write_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  a_r4_we_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sel);

  a_r4_sel_at_write_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> $past(sel));

  a_r5_addr_stable_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(sram_addr));

  a_r5_data_stable_we: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

  a_r6_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> !ram_drives);

  a_r7_oe_released_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> $past(sram_oe_n));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .sram_addr  (sram_addr),
  .sram_dq_out(sram_dq_out),
  .sram_dq_oe (sram_dq_oe),
  .sram_ce1_n (sram_ce1_n),
  .sram_ce2   (sram_ce2),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int CLK_NS = 10;
  // fast-grade figures in ns
  localparam int F_ACC = 55, F_WCYC = 55, F_WPUL = 40, F_SELE = 40;
  localparam int F_DSU = 25, F_FLT = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rsp_rdata;
  logic [16:0] sram_addr;
  logic [7:0]  sram_dq_out;
  logic        sram_dq_oe;
  logic [7:0]  sram_dq_in = 8'h00;
  logic        sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n;

  int tests = 0;
  int fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SLOW_GRADE(1'b0)) i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in), .sram_ce1_n(sram_ce1_n),
    .sram_ce2(sram_ce2), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- RAM model and pin monitor ----------------
  logic [7:0] ram [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] ram_rd(int a);
    return ram.exists(a) ? ram[a] : 8'h00;
  endfunction

  int rd_age = 0, we_age = 0, dq_age = 0, sel_age = 0, gap = 100, sel_gap = 0;
  int sel_count = 0;
  bit sel_p = 0, we_low_p = 0, dq_oe_p = 0, dq_seen = 0;
  logic [7:0]  wr_dat = '0;
  logic [16:0] wr_adr = '0;

  always @(negedge clk) begin
    bit sel, drv;
    if (rst_n) begin
      sel = !sram_ce1_n && sram_ce2;
      drv = sel && !sram_oe_n && sram_we_n;
      // R7: contention and release gap
      if (sram_dq_oe && drv) chk(0, "R7 contention", 1, 0);
      if (sram_dq_oe && !dq_oe_p)
        chk((gap - 1) * CLK_NS >= F_FLT, "R7 gap after oe", (gap - 1) * CLK_NS, F_FLT);
      gap = drv ? 0 : ((gap < 100) ? gap + 1 : gap);
      // R4: spacing of selections
      sel_gap++;
      if (sel && !sel_p) begin
        if (sel_count > 0)
          chk(sel_gap * CLK_NS >= F_WCYC, "R4 select spacing", sel_gap * CLK_NS, F_WCYC);
        sel_count++;
        sel_gap = 0;
      end
      // write pulse end: commit and measure
      if (sram_we_n && we_low_p) begin
        chk(we_age * CLK_NS >= F_WPUL, "R4 we pulse", we_age * CLK_NS, F_WPUL);
        chk(sel_age * CLK_NS >= F_SELE, "R4 select to write end", sel_age * CLK_NS, F_SELE);
        chk(dq_age * CLK_NS >= F_DSU, "R5 data setup", dq_age * CLK_NS, F_DSU);
        if (dq_age > 0) ram[int'(wr_adr)] = wr_dat;
      end
      if (!sram_we_n) begin
        we_age++;
        if (sram_dq_oe) begin
          if (!dq_seen)
            chk((we_age - 1) * CLK_NS >= F_FLT, "R5 float before drive",
                (we_age - 1) * CLK_NS, F_FLT);
          else if (sram_dq_out != wr_dat || sram_addr != wr_adr)
            chk(0, "R5 data or address moved", int'(sram_dq_out), int'(wr_dat));
          dq_seen = 1;
          dq_age++;
          wr_dat = sram_dq_out;
          wr_adr = sram_addr;
        end
      end else begin
        we_age = 0; dq_age = 0; dq_seen = 0;
      end
      sel_age = sel ? sel_age + 1 : 0;
      // read data: garbage until access time has passed
      rd_age = drv ? rd_age + 1 : 0;
      if (drv)
        sram_dq_in = (rd_age * CLK_NS >= F_ACC) ? ram_rd(int'(sram_addr))
                                                : ~ram_rd(int'(sram_addr));
      else
        sram_dq_in = 8'h00;
      sel_p = sel; we_low_p = !sram_we_n; dq_oe_p = sram_dq_oe;
    end
  end

  // ---------------- request driver ----------------
  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
    int n;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < 100);
    if (n >= 100) chk(0, "R6 ready timeout", n, 0);
    rd = rsp_rdata;
    req_valid = 1'b0;
    if (wr) shadow[int'(a)] = d;
    @(negedge clk);
    chk(req_ready == 1'b0, "R6 ready single cycle", int'(req_ready), 0);
  endtask

  function automatic logic [7:0] pat(logic [16:0] a);
    return a[7:0] ^ 8'h5A ^ {a[15:8]} ^ {7'd0, a[16]};
  endfunction

  function automatic logic [7:0] shadow_rd(int a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  initial begin
    #(CLK_NS * 150000);
    chk(0, "watchdog", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [16:0] a;
    int n;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(sram_ce1_n == 1 && sram_ce2 == 0, "R1 enables in reset", {sram_ce1_n, sram_ce2}, 2);
    chk(sram_we_n == 1 && sram_oe_n == 1, "R1 strobes in reset", {sram_we_n, sram_oe_n}, 3);
    chk(sram_dq_oe == 0 && req_ready == 0, "R1 pads and ready in reset", {sram_dq_oe, req_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sram_ce1_n == 1 && sram_ce2 == 0 && sram_dq_oe == 0, "R1 idle after reset",
        {sram_ce1_n, sram_ce2, sram_dq_oe}, 4);

    // R2, R3: sweep of writes then reads
    for (int i = 0; i < 64; i++) do_op(1'b1, 17'(i), pat(17'(i)), r);
    for (int i = 0; i < 8; i++) begin
      a = 17'h1FFFF - 17'(i * 4099);
      do_op(1'b1, a, pat(a), r);
    end
    for (int i = 0; i < 64; i++) begin
      do_op(1'b0, 17'(i), 8'h00, r);
      chk(r == pat(17'(i)), "R3 read back sweep", int'(r), int'(pat(17'(i))));
    end
    for (int i = 0; i < 8; i++) begin
      a = 17'h1FFFF - 17'(i * 4099);
      do_op(1'b0, a, 8'h00, r);
      chk(r == shadow_rd(int'(a)), "R2 high address write", int'(r), int'(shadow_rd(int'(a))));
    end

    // R7: read followed at once by write to same address (turnaround)
    do_op(1'b0, 17'h00010, 8'h00, r);
    do_op(1'b1, 17'h00010, 8'hC3, r);
    do_op(1'b0, 17'h00010, 8'h00, r);
    chk(r == 8'hC3, "R7 read-write turnaround data", int'(r), 8'hC3);

    // R8: change request fields during an access
    do_op(1'b1, 17'h00020, 8'h11, r);
    req_write = 1'b1; req_addr = 17'h00030; req_wdata = 8'h77; req_valid = 1'b1;
    repeat (2) @(negedge clk);
    req_addr = 17'h00020; req_wdata = 8'hEE; req_write = 1'b0;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    req_valid = 1'b0;
    shadow[32'h30] = 8'h77;
    @(negedge clk);
    do_op(1'b0, 17'h00030, 8'h00, r);
    chk(r == 8'h77, "R8 accepted fields kept", int'(r), 8'h77);
    do_op(1'b0, 17'h00020, 8'h00, r);
    chk(r == 8'h11, "R8 late change ignored", int'(r), 8'h11);

    // R6: ready returns the read byte and data persists
    do_op(1'b0, 17'h00005, 8'h00, r);
    repeat (4) @(negedge clk);
    chk(rsp_rdata == pat(17'd5), "R6 read data held", int'(rsp_rdata), int'(pat(17'd5)));
    chk(sram_ce1_n == 1 && sram_dq_oe == 0, "R1 idle again", {sram_ce1_n, sram_dq_oe}, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule